// File: doc/BRIEF.md
# Split-Panel LCD Refresh Sequencer

This block drives a graphic LCD whose columns are served by two controller chips: the left half of every row belongs to chip 1 and the right half to chip 2. After reset it pulses the panel's hardware reset line and waits for the line to settle. It then sends three setup commands to both chips: software reset, display on, and display start line 0. From then on it redraws the whole panel from a local framebuffer on a periodic tick.

The framebuffer is packed vertically: one byte holds eight stacked pixels. One page, meaning a band eight pixels tall, takes up WIDTH consecutive bytes, with the left half first. Each refresh walks the pages in order. For each page it sends the page-address command and the column-0 command to both chips together. It then fetches and emits data bytes in pairs: a left-half byte to chip 1, then the byte half a width further on to chip 2, both at the same column. A clear request produces a frame that writes zero to every column of every page, with both chips selected at once.

Every byte leaves through a valid/ready handshake toward a separate bus-cycle engine, which handles the electrical timing. The framebuffer is read through a single-port RAM interface with one cycle of read latency.

Top module: `split_lcd_refresh`

## Requirements
- R1: While `rstN` is low, and for exactly RST_LOW_CYC cycles after it rises, `lcdRstN` is 0 and `busValid` is 0.
- R2: Once `lcdRstN` rises, `busValid` stays low for exactly SETTLE_CYC cycles. Then three command bytes go out, in this order: 0xE2, 0xAF, 0xC0. Each has `busIsData`=0 (0 = command, 1 = data) and `busCs`=2'b11 (bit 0 selects chip 1, the left half; bit 1 selects chip 2, the right half).
- R3: While `busValid` is 1 and `busReady` is 0, `busValid`, `busByte`, `busCs` and `busIsData` hold their values into the next cycle. A byte is transferred in a cycle where both `busValid` and `busReady` are 1.
- R4: Each page of a frame begins with two command bytes to both chips: 0xB8 OR the page number, then 0x00 (column 0). Every command byte has `busCs`=2'b11.
- R5: In a refresh frame, for column c from 0 to WIDTH/2-1 of page p, the block sends data byte fb[p*WIDTH+c] with `busCs`=2'b01, then data byte fb[p*WIDTH+WIDTH/2+c] with `busCs`=2'b10. `fbAddr` always stays below WIDTH*PAGES.
- R6: A frame covers pages 0 to PAGES-1 in rising order, where PAGES = ceil(HEIGHT/8).
- R7: With `busReady` held high, consecutive refresh frames begin exactly TICK_DIV cycles apart.
- R8: A refresh tick that arrives while a frame is in progress is kept. The next frame's first `busValid` comes exactly 2 cycles after the cycle in which the previous frame's last byte is accepted.
- R9: A clear frame sends the two page commands per page, then WIDTH/2 data bytes of 0x00 with `busCs`=2'b11.
- R10: A clear request made during a frame does not interrupt that frame. A clear frame then starts 2 cycles after it ends, ahead of any pending refresh tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clearReq | input | 1 | One-cycle pulse requesting a clear frame |
| busReady | input | 1 | Bus-cycle engine accepts the current byte |
| fbRdData | input | 8 | Framebuffer read data, one cycle after the address |
| fbAddr | output | clog2(WIDTH*PAGES) | Framebuffer read address |
| busValid | output | 1 | A byte is offered to the bus-cycle engine |
| busIsData | output | 1 | 1 = display data, 0 = command |
| busCs | output | 2 | Chip selects: bit 0 = chip 1 (left), bit 1 = chip 2 (right) |
| busByte | output | 8 | Byte to transfer |
| lcdRstN | output | 1 | Active-low panel hardware reset |

## Verification
The hard case to reach is a tick landing inside a frame, and especially a clear request that collides with a pending tick. With a fast bus, a frame finishes well inside one tick period, so neither case ever occurs. The stimulus therefore throttles `busReady` with random gaps of different densities until a frame lasts longer than the tick period. It then raises a clear request in the middle of that stretched refresh and checks the order and exact start cycles of the frames that follow.

// File: rtl/lcd_seq_pkg.sv
`timescale 1ns/1ps
package lcd_seq_pkg;

  // which byte the datapath drives onto the bus
  typedef enum logic [2:0] {
    SEL_SWRST,
    SEL_DISPON,
    SEL_LINE0,
    SEL_PAGE,
    SEL_COLUMN,
    SEL_DATA
  } byteSel_e;

  // strobes from control to datapath
  typedef struct packed {
    byteSel_e sel;
    logic     posClear;
    logic     pageInc;
    logic     colStep;
    logic     sideSet;
    logic     loadRam;
  } seqCtl_t;

  localparam logic [7:0] OP_SWRST  = 8'hE2;
  localparam logic [7:0] OP_DISPON = 8'hAF;
  localparam logic [7:0] OP_LINE0  = 8'hC0;
  localparam logic [7:0] OP_PAGE   = 8'hB8;
  localparam logic [7:0] OP_COLUMN = 8'h00;

endpackage

// File: rtl/lcd_seq_datapath.sv
`timescale 1ns/1ps
module lcd_seq_datapath
  import lcd_seq_pkg::*;
#(
  parameter int WIDTH    = 122,
  parameter int HEIGHT   = 32,
  parameter int TICK_DIV = 4000000
) (
  input  logic                                         clk,
  input  logic                                         rstN,
  input  seqCtl_t                                      ctl,
  input  logic                                         clearing,
  output logic [$clog2(WIDTH*((HEIGHT+7)/8))-1:0]      fbAddr,
  input  logic [7:0]                                   fbRdData,
  output logic [7:0]                                   busByte,
  output logic [1:0]                                   busCs,
  output logic                                         busIsData,
  output logic                                         tick,
  output logic                                         lastCol,
  output logic                                         lastPage,
  output logic                                         onRight
);

  localparam int HALF  = WIDTH / 2;
  localparam int PAGES = (HEIGHT + 7) / 8;
  localparam int DEPTH = WIDTH * PAGES;
  localparam int AW    = $clog2(DEPTH);
  localparam int PW    = (PAGES > 1) ? $clog2(PAGES) : 1;
  localparam int CW    = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int TW    = $clog2(TICK_DIV);

  logic [PW-1:0] page;
  logic [CW-1:0] col;
  logic [7:0]    dataReg;
  logic [TW-1:0] tickCnt;

  // position counters and read data capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      page    <= '0;
      col     <= '0;
      onRight <= 1'b0;
      dataReg <= '0;
    end else begin
      if (ctl.posClear) begin
        page    <= '0;
        col     <= '0;
        onRight <= 1'b0;
      end else if (ctl.pageInc) begin
        page    <= page + 1'b1;
        col     <= '0;
        onRight <= 1'b0;
      end else if (ctl.colStep) begin
        col     <= col + 1'b1;
        onRight <= 1'b0;
      end else if (ctl.sideSet) begin
        onRight <= 1'b1;
      end
      if (ctl.loadRam) dataReg <= fbRdData;
    end
  end

  // refresh tick divider
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
      tick    <= 1'b0;
    end else if (tickCnt == TW'(TICK_DIV - 1)) begin
      tickCnt <= '0;
      tick    <= 1'b1;
    end else begin
      tickCnt <= tickCnt + 1'b1;
      tick    <= 1'b0;
    end
  end

  assign lastCol  = (col == CW'(HALF - 1));
  assign lastPage = (page == PW'(PAGES - 1));
  assign fbAddr   = AW'(page) * AW'(WIDTH) + (onRight ? AW'(HALF) : AW'(0)) + AW'(col);

  always_comb begin
    busIsData = 1'b0;
    busCs     = 2'b11;
    case (ctl.sel)
      SEL_SWRST:  busByte = OP_SWRST;
      SEL_DISPON: busByte = OP_DISPON;
      SEL_LINE0:  busByte = OP_LINE0;
      SEL_PAGE:   busByte = OP_PAGE | 8'(page);
      SEL_COLUMN: busByte = OP_COLUMN;
      default: begin
        busIsData = 1'b1;
        busByte   = clearing ? 8'h00 : dataReg;
        busCs     = clearing ? 2'b11 : (onRight ? 2'b10 : 2'b01);
      end
    endcase
  end

  // R5
  // addr_range_chk
  addr_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(fbAddr) < DEPTH);

  // R6
  // pos_range_chk
  pos_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (int'(page) < PAGES) && (int'(col) < HALF));

endmodule

// File: rtl/lcd_seq_control.sv
`timescale 1ns/1ps
module lcd_seq_control
  import lcd_seq_pkg::*;
#(
  parameter int RST_LOW_CYC = 200,
  parameter int SETTLE_CYC  = 2000
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    tick,
  input  logic    clearReq,
  input  logic    busReady,
  input  logic    lastCol,
  input  logic    lastPage,
  input  logic    onRight,
  output seqCtl_t ctl,
  output logic    clearing,
  output logic    busValid,
  output logic    lcdRstN
);

  localparam int DLY_MAX = (RST_LOW_CYC > SETTLE_CYC) ? RST_LOW_CYC : SETTLE_CYC;
  localparam int DW      = $clog2(DLY_MAX + 1);

  typedef enum logic [3:0] {
    S_RSTLO, S_SETTLE, S_INIT_RST, S_INIT_ON, S_INIT_LINE,
    S_IDLE, S_PAGE, S_COLUMN, S_FETCH, S_READ, S_DATA
  } state_e;

  state_e        state, nxt;
  logic [DW-1:0] dly;
  logic          tickPend, clrPend;
  logic          rstDone, settleDone, startFrame;

  assign rstDone    = (dly == DW'(RST_LOW_CYC - 1));
  assign settleDone = (dly == DW'(SETTLE_CYC - 1));
  assign startFrame = (state == S_IDLE) && (clrPend || tickPend);
  assign lcdRstN    = (state != S_RSTLO);

  always_comb begin
    ctl      = '0;
    ctl.sel  = SEL_DATA;
    nxt      = state;
    busValid = 1'b0;
    case (state)
      S_RSTLO:  if (rstDone) nxt = S_SETTLE;
      S_SETTLE: if (settleDone) nxt = S_INIT_RST;
      S_INIT_RST: begin
        busValid = 1'b1;
        ctl.sel  = SEL_SWRST;
        if (busReady) nxt = S_INIT_ON;
      end
      S_INIT_ON: begin
        busValid = 1'b1;
        ctl.sel  = SEL_DISPON;
        if (busReady) nxt = S_INIT_LINE;
      end
      S_INIT_LINE: begin
        busValid = 1'b1;
        ctl.sel  = SEL_LINE0;
        if (busReady) nxt = S_IDLE;
      end
      S_IDLE: if (startFrame) begin
        ctl.posClear = 1'b1;
        nxt          = S_PAGE;
      end
      S_PAGE: begin
        busValid = 1'b1;
        ctl.sel  = SEL_PAGE;
        if (busReady) nxt = S_COLUMN;
      end
      S_COLUMN: begin
        busValid = 1'b1;
        ctl.sel  = SEL_COLUMN;
        if (busReady) nxt = clearing ? S_DATA : S_FETCH;
      end
      S_FETCH: nxt = S_READ;
      S_READ: begin
        ctl.loadRam = 1'b1;
        nxt         = S_DATA;
      end
      S_DATA: begin
        busValid = 1'b1;
        if (busReady) begin
          if (!clearing && !onRight) begin
            ctl.sideSet = 1'b1;
            nxt         = S_FETCH;
          end else if (lastCol) begin
            if (lastPage) nxt = S_IDLE;
            else begin
              ctl.pageInc = 1'b1;
              nxt         = S_PAGE;
            end
          end else begin
            ctl.colStep = 1'b1;
            nxt         = clearing ? S_DATA : S_FETCH;
          end
        end
      end
      default: nxt = S_RSTLO;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_RSTLO;
      dly      <= '0;
      tickPend <= 1'b0;
      clrPend  <= 1'b0;
      clearing <= 1'b0;
    end else begin
      state <= nxt;
      if ((state == S_RSTLO && !rstDone) || (state == S_SETTLE && !settleDone))
        dly <= dly + 1'b1;
      else
        dly <= '0;
      clrPend  <= (clrPend & ~startFrame) | clearReq;
      tickPend <= (tickPend & ~(startFrame & ~clrPend)) | tick;
      if (startFrame) clearing <= clrPend;
    end
  end

  // R8
  // pend_hold_chk
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> tickPend);

  // R10
  // clr_hold_chk
  clr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    clearReq |=> clrPend);

  // R1
  // quiet_reset_chk
  quiet_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lcdRstN |-> !busValid);

endmodule

// File: rtl/split_lcd_refresh.sv
`timescale 1ns/1ps
module split_lcd_refresh
  import lcd_seq_pkg::*;
#(
  parameter int WIDTH       = 122,
  parameter int HEIGHT      = 32,
  parameter int TICK_DIV    = 4000000,
  parameter int RST_LOW_CYC = 200,
  parameter int SETTLE_CYC  = 2000
) (
  input  logic                                    clk,
  input  logic                                    rstN,
  input  logic                                    clearReq,
  input  logic                                    busReady,
  input  logic [7:0]                              fbRdData,
  output logic [$clog2(WIDTH*((HEIGHT+7)/8))-1:0] fbAddr,
  output logic                                    busValid,
  output logic                                    busIsData,
  output logic [1:0]                              busCs,
  output logic [7:0]                              busByte,
  output logic                                    lcdRstN
);

  seqCtl_t ctl;
  logic    clearing, tick, lastCol, lastPage, onRight;

  lcd_seq_control #(
    .RST_LOW_CYC(RST_LOW_CYC),
    .SETTLE_CYC (SETTLE_CYC)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .tick     (tick),
    .clearReq (clearReq),
    .busReady (busReady),
    .lastCol  (lastCol),
    .lastPage (lastPage),
    .onRight  (onRight),
    .ctl      (ctl),
    .clearing (clearing),
    .busValid (busValid),
    .lcdRstN  (lcdRstN)
  );

  lcd_seq_datapath #(
    .WIDTH   (WIDTH),
    .HEIGHT  (HEIGHT),
    .TICK_DIV(TICK_DIV)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .clearing (clearing),
    .fbAddr   (fbAddr),
    .fbRdData (fbRdData),
    .busByte  (busByte),
    .busCs    (busCs),
    .busIsData(busIsData),
    .tick     (tick),
    .lastCol  (lastCol),
    .lastPage (lastPage),
    .onRight  (onRight)
  );

  // R3
  // hold_chk
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busReady) |=> (busValid && $stable(busByte) && $stable(busCs) && $stable(busIsData)));

  // R4
  // cmd_both_chk
  cmd_both_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busIsData) |-> (busCs == 2'b11));

  // R5
  // data_target_chk
  data_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busIsData && (busByte != 8'h00)) |-> $onehot(busCs));

endmodule

// File: tb/split_lcd_refresh_test.sv
`timescale 1ns/1ps
module split_lcd_refresh_test;

  localparam int W     = 122;
  localparam int H     = 32;
  localparam int TDIV  = 1600;
  localparam int RLOW  = 8;
  localparam int SETL  = 20;
  localparam int HALF  = W / 2;
  localparam int PAGES = (H + 7) / 8;
  localparam int DEPTH = W * PAGES;
  localparam int AW    = $clog2(DEPTH);

  typedef struct {
    bit       isData;
    bit [1:0] cs;
    bit [7:0] b;
    int       stamp;
    int       vstart;
  } xfer_t;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          clearReq = 1'b0;
  logic          busReady = 1'b0;
  logic [7:0]    fbRdData = 8'h00;
  logic [AW-1:0] fbAddr;
  logic          busValid, busIsData, lcdRstN;
  logic [1:0]    busCs;
  logic [7:0]    busByte;

  logic [7:0] fb [DEPTH];
  xfer_t      q[$];
  int cyc = 0, lowCnt = 0, riseCyc = -1, vs = 0;
  int nChecks = 0, nFails = 0, readyMode = 0;
  bit inFlight = 1'b0;

  always #2.5 clk = ~clk;

  split_lcd_refresh #(
    .WIDTH(W), .HEIGHT(H), .TICK_DIV(TDIV), .RST_LOW_CYC(RLOW), .SETTLE_CYC(SETL)
  ) uut (
    .clk(clk), .rstN(rstN), .clearReq(clearReq), .busReady(busReady),
    .fbRdData(fbRdData), .fbAddr(fbAddr), .busValid(busValid),
    .busIsData(busIsData), .busCs(busCs), .busByte(busByte), .lcdRstN(lcdRstN)
  );

  // framebuffer RAM model, one cycle latency
  initial forever begin
    @(posedge clk);
    fbRdData <= fb[fbAddr];
  end

  // ready driver
  initial forever begin
    @(posedge clk);
    #1;
    case (readyMode)
      0:       busReady = 1'b1;
      1:       busReady = ($urandom % 2) == 0;
      default: busReady = ($urandom % 5) == 0;
    endcase
  end

  // monitor, samples mid-cycle
  initial forever begin
    @(negedge clk);
    cyc++;
    if (rstN) begin
      if (!lcdRstN) lowCnt++;
      else if (riseCyc < 0) riseCyc = cyc;
    end
    if (busValid && !inFlight) begin
      vs = cyc;
      inFlight = 1'b1;
    end
    if (busValid && busReady) begin
      q.push_back('{busIsData, busCs, busByte, cyc, vs});
      inFlight = 1'b0;
    end
  end

  function automatic logic [7:0] expByte(int p, int c, bit right);
    return fb[p * W + (right ? HALF : 0) + c];
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic expectOne(bit d, bit [1:0] cs, bit [7:0] b, string req, output xfer_t r);
    while (q.size() == 0) @(negedge clk);
    r = q.pop_front();
    check(r.isData == d && r.cs == cs && r.b == b, req, "transfer {isData,cs,byte}",
          int'({r.isData, r.cs, r.b}), int'({d, cs, b}));
  endtask

  task automatic expectFrame(bit clr, output int firstV, output int lastS);
    xfer_t r;
    firstV = 0;
    for (int p = 0; p < PAGES; p++) begin
      expectOne(1'b0, 2'b11, 8'hB8 | 8'(p), "R4 R6 page cmd", r);
      if (p == 0) firstV = r.vstart;
      expectOne(1'b0, 2'b11, 8'h00, "R4 column cmd", r);
      for (int c = 0; c < HALF; c++) begin
        if (clr) expectOne(1'b1, 2'b11, 8'h00, "R9 clear byte", r);
        else begin
          expectOne(1'b1, 2'b01, expByte(p, c, 1'b0), "R5 left byte", r);
          expectOne(1'b1, 2'b10, expByte(p, c, 1'b1), "R5 right byte", r);
        end
      end
    end
    lastS = r.stamp;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    xfer_t r;
    int s1, l1, s2, l2, sx, lx, l6, s7, l7, l8, s9, l9;
    void'($urandom(32'h1CD5EED));
    for (int i = 0; i < DEPTH; i++) fb[i] = 8'($urandom);
    fb[0] = 8'hFF;
    fb[HALF] = 8'h80;
    fb[HALF - 1] = 8'h00;
    fb[DEPTH - 1] = 8'h01;

    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(busValid == 1'b0 && lcdRstN == 1'b0, "R1", "reset {busValid,lcdRstN}",
          int'({busValid, lcdRstN}), 0);
    @(posedge clk);
    #1 rstN = 1'b1;

    // R2 init sequence and settle time
    expectOne(1'b0, 2'b11, 8'hE2, "R2 swreset", r);
    check(r.vstart - riseCyc == SETL, "R2", "settle cycles", r.vstart - riseCyc, SETL);
    check(lowCnt == RLOW, "R1", "reset low cycles", lowCnt, RLOW);
    expectOne(1'b0, 2'b11, 8'hAF, "R2 display on", r);
    expectOne(1'b0, 2'b11, 8'hC0, "R2 start line", r);

    // R7 period with free-running bus
    expectFrame(1'b0, s1, l1);
    expectFrame(1'b0, s2, l2);
    check(s2 - s1 == TDIV, "R7", "frame period", s2 - s1, TDIV);

    // R3 R5 random stalls
    readyMode = 1;
    expectFrame(1'b0, sx, lx);
    expectFrame(1'b0, sx, lx);

    // R8 frames longer than tick period
    readyMode = 2;
    expectFrame(1'b0, sx, lx);
    expectFrame(1'b0, sx, l6);
    expectFrame(1'b0, s7, l7);
    check(s7 - l6 == 2, "R8", "pending tick gap", s7 - l6, 2);

    // R10 clear during refresh, with tick pending
    readyMode = 0;
    while (q.size() == 0) @(negedge clk);
    @(posedge clk);
    #1 clearReq = 1'b1;
    @(posedge clk);
    #1 clearReq = 1'b0;
    expectFrame(1'b0, sx, l8);
    expectFrame(1'b1, s9, l9);
    check(s9 - l8 == 2, "R10", "clear start gap", s9 - l8, 2);
    expectFrame(1'b0, sx, lx);
    check(sx - l9 == 2, "R10", "pending refresh after clear gap", sx - l9, 2);

    summary();
    $finish;
  end

endmodule